// File: doc/BRIEF.md
# Pipelined Third-Order MASH Sigma-Delta Modulator

This block turns a static fractional word into a stream of small integer codes whose long-run mean equals that fraction. A fractional-N divider can then take one code per reference cycle and hop between neighbouring division ratios. Three first-order accumulator stages are cascaded. Each stage adds its input into its own register modulo 2^WORD_W and raises a carry when the sum wraps. The register contents then become the input of the following stage. A cancellation network combines the three carries so that the quantisation error of the first two stages is shaped out. An encoder maps the signed result onto an unsigned three-bit code.

Every accumulator is cut into slices of SLICE_W bits. A registered carry links each slice to the one above it, so one adder slice sits between clock edges. Input bits are skewed per slice to meet their carries. The stages are chained in skewed form, so no realignment is needed between stages. Each carry counts as −1 when set and 0 when clear, rather than +1 and 0. With this convention the cancellation arithmetic needs only a 2-bit and a 3-bit adder-subtractor.

The block has no state machine. Its only mode control is `en_i`: every register advances on a rising clock edge with `en_i` high (an enabled edge) and holds otherwise. Reset is synchronous and active high.

Top module: `mash111_mod`

## Requirements
- R1: After reset is released, `code_o` is 3 (3'b011, the code for a signed result of zero). It stays 3 for the first 6 enabled edges. A reset in the middle of a run returns the block to this state.
- R2: `code_o` equals 3 − y, where y is the signed cancellation result in −4..3. So y = 3 gives code 0 and y = −4 gives code 7. In bits, y2 passes straight through and y1 and y0 are inverted.
- R3: With `word_i` held at 0, every code is 3.
- R4: With the defaults WORD_W=20 and SLICE_W=5, the code after enabled edge k equals the result of a non-pipelined model for the word taken at enabled edge k−6. That model uses three cascaded 20-bit accumulators, each fed the new contents of the one before it. With ci the carry of stage i, the result is y = r1 + t − t' and t = r2 + r3 − r3', where ri = −ci and a prime marks the previous sample.
- R5: On a clock edge with `en_i` low and no reset, `code_o` does not change.
- R6: For a constant word F over N samples, the sum S of the signed results satisfies |S·2^20 + N·F| ≤ 3·2^20. The long-run mean is therefore −F/2^20.
- R7: The value on `word_i` at an edge with `en_i` low has no effect. Later codes equal those of the model stepped only on enabled edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_i | input | 1 | Synchronous active-high reset |
| en_i | input | 1 | Advance enable for every register |
| word_i | input | WORD_W | Unsigned fractional word (fraction = word_i / 2^WORD_W) |
| code_o | output | 3 | Unsigned divider offset code, 3 − y |

## Verification
The bench goes after the pipeline alignment. If any skew tap, carry alignment delay or differentiator tap were placed one cycle off, some sample would disagree with the non-pipelined model, and the error would move the mean away from −F/2^20. The edge words 0, 1, one half and all-ones test the encoder, carry wrap and range extremes. A wrong encoder polarity would report the negated mean. Stall cycles with a different value on the word input expose a design that leaks the word or advances some register while disabled. A mid-run reset catches any delay tap that is not cleared, because such a tap would emit a non-zero code during the fill window.

// File: rtl/mash111_pkg.sv
package mash111_pkg;

    // Number of cascaded first-order stages (fixed by the 1-1-1 structure)
    localparam int NSTAGE = 3;

    // Code emitted for a signed cancellation result of zero
    localparam logic [2:0] CODE_ZERO = 3'b011;

    // Map a signed result y in -4..3 to the unsigned code 3 - y:
    // y2 passes straight through, y1 and y0 are inverted.
    function automatic logic [2:0] enc_code(input logic [2:0] y);
        return {y[2], ~y[1], ~y[0]};
    endfunction

    // Enabled edges from taking a word to showing its code
    function automatic int pipe_lat(input int nslice);
        return nslice + NSTAGE - 1;
    endfunction

endpackage

// File: rtl/mash111_slice.sv
module mash111_slice #(
    parameter int SW = 5
) (
    input  logic          clk_i,
    input  logic          rst_i,
    input  logic          en_i,
    input  logic [SW-1:0] add_i,
    input  logic          cin_i,
    output logic [SW-1:0] acc_o,
    output logic          cout_o
);

    logic [SW:0] sum_c;

    always_comb begin
        sum_c = {1'b0, acc_o} + {1'b0, add_i} + {{SW{1'b0}}, cin_i};
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            acc_o  <= '0;
            cout_o <= 1'b0;
        end else if (en_i) begin
            acc_o  <= sum_c[SW-1:0];
            cout_o <= sum_c[SW];
        end
    end

    // A wrap leaves the slice below the addend it just took in; no wrap leaves it at or above.
    p_slice_carry_r4: assert property (@(posedge clk_i) disable iff (rst_i)
        $past(en_i && !rst_i) |->
            (cout_o == (acc_o < ({1'b0, $past(add_i)} + {{SW{1'b0}}, $past(cin_i)}))));

endmodule

// File: rtl/mash111_skew.sv
module mash111_skew #(
    parameter int WORD_W  = 20,
    parameter int SLICE_W = 5
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              en_i,
    input  logic [WORD_W-1:0] word_i,
    output logic [WORD_W-1:0] skew_o
);

    localparam int NSLICE = WORD_W / SLICE_W;

    // Slice j is delayed by j enabled edges so that it meets its ripple carry.
    for (genvar j = 0; j < NSLICE; j++) begin : g_lane
        if (j == 0) begin : g_direct
            assign skew_o[SLICE_W-1:0] = word_i[SLICE_W-1:0];
        end else begin : g_delay
            logic [SLICE_W-1:0] tap_q [j];
            always_ff @(posedge clk_i) begin
                if (rst_i) begin
                    for (int i = 0; i < j; i++) tap_q[i] <= '0;
                end else if (en_i) begin
                    tap_q[0] <= word_i[j*SLICE_W +: SLICE_W];
                    for (int i = 1; i < j; i++) tap_q[i] <= tap_q[i-1];
                end
            end
            assign skew_o[j*SLICE_W +: SLICE_W] = tap_q[j-1];
        end
    end

endmodule

// File: rtl/mash111_stage.sv
module mash111_stage #(
    parameter int WORD_W  = 20,
    parameter int SLICE_W = 5
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              en_i,
    input  logic [WORD_W-1:0] skew_in_i,
    output logic [WORD_W-1:0] skew_acc_o,
    output logic              carry_o
);

    localparam int NSLICE = WORD_W / SLICE_W;

    logic [NSLICE:0] cy;
    assign cy[0] = 1'b0;

    for (genvar j = 0; j < NSLICE; j++) begin : g_slice
        mash111_slice #(.SW(SLICE_W)) u_slice (
            .clk_i  (clk_i),
            .rst_i  (rst_i),
            .en_i   (en_i),
            .add_i  (skew_in_i[j*SLICE_W +: SLICE_W]),
            .cin_i  (cy[j]),
            .acc_o  (skew_acc_o[j*SLICE_W +: SLICE_W]),
            .cout_o (cy[j+1])
        );
    end

    // Carry register of the top slice is the stage carry-out
    assign carry_o = cy[NSLICE];

endmodule

// File: rtl/mash111_ecu.sv
module mash111_ecu
    import mash111_pkg::*;
(
    input  logic       clk_i,
    input  logic       rst_i,
    input  logic       en_i,
    input  logic       c1_i,
    input  logic       c2_i,
    input  logic       c3_i,
    output logic [2:0] code_o
);

    // Alignment: stage k carry lags stage 1 by k-1 edges
    logic       c1_d1_q, c1_d2_q, c2_d1_q;
    // Differentiator taps
    logic       c3_p_q;
    logic [1:0] t_p_q;
    logic [1:0] t_c;
    logic [2:0] y_c;

    // Recoded carry: set means -1, which is {2{c}} or {3{c}} in two's complement
    always_comb begin
        t_c = {2{c2_d1_q}} + {2{c3_i}} - {2{c3_p_q}};
        y_c = {3{c1_d2_q}} + {t_c[1], t_c} - {t_p_q[1], t_p_q};
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            c1_d1_q <= 1'b0;
            c1_d2_q <= 1'b0;
            c2_d1_q <= 1'b0;
            c3_p_q  <= 1'b0;
            t_p_q   <= '0;
            code_o  <= CODE_ZERO;
        end else if (en_i) begin
            c1_d1_q <= c1_i;
            c1_d2_q <= c1_d1_q;
            c2_d1_q <= c2_i;
            c3_p_q  <= c3_i;
            t_p_q   <= t_c;
            code_o  <= enc_code(y_c);
        end
    end

    p_hold_r5: assert property (@(posedge clk_i) disable iff (rst_i)
        (!en_i && !rst_i) |=> $stable(code_o));

    p_quiet_code_r2: assert property (@(posedge clk_i) disable iff (rst_i)
        ($past(en_i && !rst_i) &&
         $past(!c1_d2_q && !c2_d1_q && !c3_i && !c3_p_q && (t_p_q == 2'b00)))
        |-> (code_o == CODE_ZERO));

endmodule

// File: rtl/mash111_mod.sv
module mash111_mod
    import mash111_pkg::*;
#(
    parameter int WORD_W  = 20,
    parameter int SLICE_W = 5
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              en_i,
    input  logic [WORD_W-1:0] word_i,
    output logic [2:0]        code_o
);

    localparam int NSLICE = WORD_W / SLICE_W;
    localparam int LAT    = pipe_lat(NSLICE);
    localparam int FCW    = $clog2(LAT + 2);

    logic [WORD_W-1:0] stg_w [NSTAGE+1];
    logic [NSTAGE-1:0] carry_w;

    mash111_skew #(.WORD_W(WORD_W), .SLICE_W(SLICE_W)) u_skew (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .en_i   (en_i),
        .word_i (word_i),
        .skew_o (stg_w[0])
    );

    // Stages chained in skewed form: residue of stage k feeds stage k+1
    for (genvar k = 0; k < NSTAGE; k++) begin : g_stage
        mash111_stage #(.WORD_W(WORD_W), .SLICE_W(SLICE_W)) u_stage (
            .clk_i      (clk_i),
            .rst_i      (rst_i),
            .en_i       (en_i),
            .skew_in_i  (stg_w[k]),
            .skew_acc_o (stg_w[k+1]),
            .carry_o    (carry_w[k])
        );
    end

    mash111_ecu u_ecu (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .en_i   (en_i),
        .c1_i   (carry_w[0]),
        .c2_i   (carry_w[1]),
        .c3_i   (carry_w[2]),
        .code_o (code_o)
    );

    // Fill window counter used by the checks below
    logic [FCW-1:0] fill_q;
    always_ff @(posedge clk_i) begin
        if (rst_i)                                   fill_q <= '0;
        else if (en_i && (fill_q <= FCW'(LAT)))      fill_q <= fill_q + 1'b1;
    end

    p_fill_zero_r1: assert property (@(posedge clk_i) disable iff (rst_i)
        (fill_q <= FCW'(LAT)) |-> (code_o == CODE_ZERO));

    p_clear_residue_r1: assert property (@(posedge clk_i) disable iff (rst_i)
        (fill_q == '0) |-> (stg_w[NSTAGE] == '0));

endmodule

// File: tb/tb_mash111_mod.sv
`timescale 1ns/1ps
module tb_mash111_mod;

    localparam int LAT  = 6;
    localparam int NVEC = 6;
    localparam logic [19:0] VEC_W [NVEC] = '{20'h00000, 20'h00001, 20'h80000,
                                            20'hFFFFF, 20'h12345, 20'h5A5A0};
    localparam int          VEC_N [NVEC] = '{512, 4096, 4096, 4096, 4096, 65536};

    logic        clk = 1'b0;
    logic        rst_i = 1'b1;
    logic        en_i = 1'b0;
    logic [19:0] word_i = '0;
    logic [2:0]  code_o;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    mash111_mod dut (
        .clk_i  (clk),
        .rst_i  (rst_i),
        .en_i   (en_i),
        .word_i (word_i),
        .code_o (code_o)
    );

    // Non-pipelined reference model state
    logic [19:0] m_e1, m_e2, m_e3;
    int m_c3p, m_tp;
    int hist [LAT+1];

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic model_reset();
        m_e1 = '0; m_e2 = '0; m_e3 = '0; m_c3p = 0; m_tp = 0;
        for (int i = 0; i <= LAT; i++) hist[i] = 0;
    endtask

    task automatic model_step(input logic [19:0] x, output int y);
        logic [20:0] s;
        int c1, c2, c3, t;
        s = {1'b0, m_e1} + {1'b0, x};    c1 = int'(s[20]); m_e1 = s[19:0];
        s = {1'b0, m_e2} + {1'b0, m_e1}; c2 = int'(s[20]); m_e2 = s[19:0];
        s = {1'b0, m_e3} + {1'b0, m_e2}; c3 = int'(s[20]); m_e3 = s[19:0];
        t = -c2 - c3 + m_c3p;
        y = -c1 + t - m_tp;
        m_c3p = c3;
        m_tp  = t;
    endtask

    task automatic do_reset();
        rst_i = 1'b1; en_i = 1'b0;
        @(posedge clk); @(posedge clk); #1;
        rst_i = 1'b0;
        model_reset();
        chk(code_o == 3'd3, "R1 reset code", int'(code_o), 3);
    endtask

    // One clock edge; drive away from the edge, sample 1 ns after it.
    task automatic run_step(input logic [19:0] w, input bit e, input string tag);
        int y, expc, prev;
        prev = int'(code_o);
        word_i = w; en_i = e;
        @(posedge clk); #1;
        if (e) begin
            model_step(w, y);
            for (int i = LAT; i > 0; i--) hist[i] = hist[i-1];
            hist[0] = y;
            expc = 3 - hist[LAT];
            chk(int'(code_o) == expc, tag, int'(code_o), expc);
        end else begin
            chk(int'(code_o) == prev, "R5 hold on stall", int'(code_o), prev);
        end
    endtask

    initial begin
        longint sum, dev, nf;
        model_reset();
        // Vector table: each entry is a fresh run with a constant word
        for (int v = 0; v < NVEC; v++) begin
            do_reset();
            sum = 0;
            for (int k = 1; k <= VEC_N[v] + LAT; k++) begin
                run_step(VEC_W[v], 1'b1, "R2/R4 reference match");
                if (k <= LAT)
                    chk(code_o == 3'd3, "R1 fill window", int'(code_o), 3);
                if (VEC_W[v] == 20'h0)
                    chk(code_o == 3'd3, "R3 zero word", int'(code_o), 3);
                if (k > LAT) sum += longint'(3 - int'(code_o));
            end
            nf  = longint'(VEC_N[v]) * longint'(VEC_W[v]);
            dev = sum * 64'd1048576 + nf;
            if (dev < 0) dev = -dev;
            chk(dev <= 3 * 64'd1048576, "R6 long-run mean",
                int'(sum), -int'(nf / 64'd1048576));
        end

        // Stalls with a foreign word on the input: R5 and R7
        do_reset();
        for (int k = 0; k < 300; k++) begin
            if (k % 3 == 2) run_step(20'hDB975, 1'b0, "R5 stall");
            else            run_step(20'h2468A, 1'b1, "R7 word ignored while stalled");
        end

        // Reset in the middle of a run: R1
        do_reset();
        for (int k = 0; k < 50; k++) run_step(20'h7FFFF, 1'b1, "R4 before mid-run reset");
        do_reset();
        for (int k = 1; k <= 40; k++) begin
            run_step(20'h7FFFF, 1'b1, "R4 after mid-run reset");
            if (k <= LAT) chk(code_o == 3'd3, "R1 refill after reset", int'(code_o), 3);
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        #1000000;
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    end

endmodule